// File: doc/BRIEF.md
# EPP Host-to-Peripheral Cycle Bridge

This block turns accesses from a simple synchronous host I/O bus into Enhanced Parallel Port transfers. The host side uses active-low read and write strobes, a three-bit register offset, byte-wide write and read data, and a ready output. The peripheral side has byte-wide data with separate input, output and output-enable lines (the pad ring joins them into the bidirectional bus), active-low data and address strobes, an active-low write line, a direction output, an active-low wait input, an interrupt line passed through, and an active-low peripheral reset.

A host access at offset 3 runs an address-strobe transfer and an access at offset 4 runs a data-strobe transfer. Offsets 0 to 2 reach local registers and never strobe the peripheral. While the peripheral holds wait asserted, the host ready output goes low so the host cycle stretches. If wait never releases, a programmable limit ends the stretch and sets a sticky time-out flag. Writes are latched when the host releases its strobe. Reads capture the peripheral byte on the clock where wait is seen released, and that byte stays readable afterwards.

Top module: `epp_bridge`

## Requirements
- R1: When the host strobe goes low at offset 3, `paddr_stb_n` goes low after the next clock edge. At offset 4, `pdata_stb_n` does so instead. Offsets 0 to 2 assert neither strobe, and the two strobes are never low together.
- R2: `host_rdy` is low exactly while a peripheral strobe is active and `pwait_n` is low. The strobe stays active after wait releases, until the host releases its strobe.
- R3: If `host_rdy` has been low for TMO_CYCLES clock cycles, it is released and a sticky time-out flag (status bit 0 at offset 1) is set. On a read that times out, the read data becomes 8'hFF. Writing a byte with bit 0 set to offset 1 clears the flag.
- R4: During a write transfer, `pwrite_n` is low, `pd_oe` is high, `pdir` is low and `pd_out` carries the host byte. After the host raises `host_wr_n`, the strobe rises at the next clock edge. The byte is kept in an output latch that goes on driving `pd_out` and reads back at offset 0.
- R5: During a read transfer, `pwrite_n` is high, `pdir` is high and `pd_oe` is low. `pd_in` is captured on the clock edge where `pwait_n` is high and is returned on `host_rdata` at offsets 3 and 4. The strobe rises at the clock edge after `host_rd_n` rises.
- R6: The control register at offset 2 uses bit 0 as the direction bit. When it is 1, `pdir` is high, `pd_oe` is low and `pwrite_n` is high while no transfer runs. When it is 0, `pdir` rests low.
- R7: Bit 1 of the control register drives `preset_n` low while it is set. The control register reads back at offset 2.
- R8: `pint_out` follows `pint_in` without inversion. Status bit 2 shows `pint_in` and status bit 1 shows that wait is asserted.
- R9: After reset, both strobes and `pwrite_n` are high, `pdir` is low, `pd_oe` is high, `preset_n` and `host_rdy` are high, and the control register, the output latch and the time-out flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rdata | output | 8 | Host read byte |
| host_rdy | output | 1 | Host ready; low stretches the host cycle |
| pd_in | input | 8 | Peripheral data bus input |
| pd_out | output | 8 | Peripheral data bus output |
| pd_oe | output | 1 | Peripheral data bus output enable |
| pdata_stb_n | output | 1 | Data strobe, active low |
| paddr_stb_n | output | 1 | Address strobe, active low |
| pwrite_n | output | 1 | Write line, active low |
| pdir | output | 1 | Direction: 0 output, 1 input |
| pwait_n | input | 1 | Peripheral wait, active low |
| pint_in | input | 1 | Peripheral interrupt, active high |
| pint_out | output | 1 | Interrupt passed to the host |
| preset_n | output | 1 | Peripheral reset, active low |

## Verification
The bench builds the bridge with TMO_CYCLES set to 16 instead of the default 256. At that size a peripheral that never releases wait reaches the time-out within a few clocks, so the exact number of stretched cycles can be counted and the sticky flag and the 8'hFF read byte can be checked in the same run. Random transfers use wait stretches of zero to five cycles, which stay below the limit. This lets normal stretching and expiry be exercised separately.

// File: rtl/epp_pkg.sv
package epp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_DONE = 2'd2
    } cyc_state_e;

    typedef enum logic {
        STB_DATA = 1'b0,
        STB_ADDR = 1'b1
    } stb_kind_e;

    localparam logic [2:0] OFS_LATCH = 3'd0;
    localparam logic [2:0] OFS_STAT  = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_ADDR  = 3'd3;
    localparam logic [2:0] OFS_DATA  = 3'd4;

    typedef struct packed {
        logic      active;
        logic      is_read;
        stb_kind_e kind;
    } cyc_info_t;

    typedef struct packed {
        logic prst;
        logic dir;
    } ctrl_t;

    function automatic logic is_epp_ofs(input logic [2:0] ofs);
        return (ofs == OFS_ADDR) || (ofs == OFS_DATA);
    endfunction

    function automatic logic [7:0] pack_status(input logic tmo,
                                               input logic wait_act,
                                               input logic irq);
        return {5'b0, irq, wait_act, tmo};
    endfunction

endpackage

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
    import epp_pkg::*;
#(
    parameter int TMO_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] host_addr,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    input  logic       pwait_n,
    output cyc_info_t  info,
    output logic       host_rdy,
    output logic       capture,
    output logic       tmo_hit,
    output logic       wr_done
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

    cyc_state_e state;
    logic       is_read;
    stb_kind_e  kind;
    logic [CW-1:0] cnt;
    logic       released;

    assign released = is_read ? host_rd_n : host_wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            is_read <= 1'b0;
            kind    <= STB_DATA;
            cnt     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (is_epp_ofs(host_addr) && (!host_rd_n || !host_wr_n)) begin
                        state   <= ST_ACT;
                        is_read <= !host_rd_n;
                        kind    <= (host_addr == OFS_ADDR) ? STB_ADDR : STB_DATA;
                    end
                end
                ST_ACT: begin
                    if (released)            state <= ST_IDLE;
                    else if (pwait_n)        state <= ST_DONE;
                    else if (cnt == CNT_LAST) state <= ST_DONE;
                    else                     cnt <= cnt + 1'b1;
                end
                ST_DONE: begin
                    if (released) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        info.active  = (state != ST_IDLE);
        info.is_read = is_read;
        info.kind    = kind;
        host_rdy     = !((state == ST_ACT) && !pwait_n);
        capture      = (state == ST_ACT) && !released && pwait_n && is_read;
        tmo_hit      = (state == ST_ACT) && !released && !pwait_n && (cnt == CNT_LAST);
        wr_done      = (state != ST_IDLE) && !is_read && host_wr_n;
    end

endmodule

// File: rtl/epp_host_regs.sv
module epp_host_regs
    import epp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_wr_n,
    input  cyc_info_t  info,
    input  logic       capture,
    input  logic       tmo_hit,
    input  logic       wr_done,
    input  logic [7:0] pd_in,
    input  logic       pwait_n,
    input  logic       pint_in,
    output ctrl_t      ctrl,
    output logic [7:0] out_latch,
    output logic [7:0] wr_hold,
    output logic [7:0] host_rdata
);
    logic       wr_n_q;
    logic       reg_wr;
    logic       tmo_flag;
    logic [7:0] rd_latch;

    assign reg_wr = !wr_n_q && host_wr_n && !is_epp_ofs(host_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q    <= 1'b1;
            wr_hold   <= '0;
            out_latch <= '0;
            rd_latch  <= '0;
            tmo_flag  <= 1'b0;
            ctrl      <= '0;
        end else begin
            wr_n_q <= host_wr_n;
            if (!host_wr_n) wr_hold <= host_wdata;

            if (wr_done || (reg_wr && host_addr == OFS_LATCH))
                out_latch <= wr_hold;

            if (capture)                       rd_latch <= pd_in;
            else if (tmo_hit && info.is_read)  rd_latch <= 8'hFF;

            if (tmo_hit)
                tmo_flag <= 1'b1;
            else if (reg_wr && host_addr == OFS_STAT && wr_hold[0])
                tmo_flag <= 1'b0;

            if (reg_wr && host_addr == OFS_CTRL)
                ctrl <= ctrl_t'(wr_hold[1:0]);
        end
    end

    always_comb begin
        unique case (host_addr)
            OFS_LATCH: host_rdata = out_latch;
            OFS_STAT:  host_rdata = pack_status(tmo_flag, !pwait_n, pint_in);
            OFS_CTRL:  host_rdata = {6'b0, ctrl};
            OFS_ADDR,
            OFS_DATA:  host_rdata = rd_latch;
            default:   host_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/epp_bridge.sv
module epp_bridge
    import epp_pkg::*;
#(
    parameter int TMO_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    output logic [7:0] host_rdata,
    output logic       host_rdy,
    input  logic [7:0] pd_in,
    output logic [7:0] pd_out,
    output logic       pd_oe,
    output logic       pdata_stb_n,
    output logic       paddr_stb_n,
    output logic       pwrite_n,
    output logic       pdir,
    input  logic       pwait_n,
    input  logic       pint_in,
    output logic       pint_out,
    output logic       preset_n
);
    cyc_info_t  info;
    ctrl_t      ctrl;
    logic       capture;
    logic       tmo_hit;
    logic       wr_done;
    logic [7:0] out_latch;
    logic [7:0] wr_hold;
    logic       in_write;
    logic       in_read;

    epp_cycle_fsm #(.TMO_CYCLES(TMO_CYCLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .host_addr (host_addr),
        .host_rd_n (host_rd_n),
        .host_wr_n (host_wr_n),
        .pwait_n   (pwait_n),
        .info      (info),
        .host_rdy  (host_rdy),
        .capture   (capture),
        .tmo_hit   (tmo_hit),
        .wr_done   (wr_done)
    );

    epp_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr_n  (host_wr_n),
        .info       (info),
        .capture    (capture),
        .tmo_hit    (tmo_hit),
        .wr_done    (wr_done),
        .pd_in      (pd_in),
        .pwait_n    (pwait_n),
        .pint_in    (pint_in),
        .ctrl       (ctrl),
        .out_latch  (out_latch),
        .wr_hold    (wr_hold),
        .host_rdata (host_rdata)
    );

    always_comb begin
        in_write    = info.active && !info.is_read;
        in_read     = info.active && info.is_read;
        pdata_stb_n = !(info.active && info.kind == STB_DATA);
        paddr_stb_n = !(info.active && info.kind == STB_ADDR);
        pwrite_n    = !in_write;
        pdir        = in_read || (ctrl.dir && !in_write);
        pd_oe       = !pdir;
        pd_out      = in_write ? wr_hold : out_latch;
        preset_n    = !ctrl.prst;
        pint_out    = pint_in;
    end

endmodule

// File: rtl/epp_bridge_chk.sv
module epp_bridge_chk #(
    parameter int TMO_CYCLES = 256
) (
    input logic clk,
    input logic rst,
    input logic host_rdy,
    input logic host_rd_n,
    input logic host_wr_n,
    input logic pwait_n,
    input logic pdata_stb_n,
    input logic paddr_stb_n,
    input logic pwrite_n,
    input logic pdir,
    input logic pd_oe
);
    localparam int CW = $clog2(TMO_CYCLES + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(TMO_CYCLES);

    logic [CW-1:0] low_run;
    logic          stb_on;

    assign stb_on = !pdata_stb_n || !paddr_stb_n;

    always_ff @(posedge clk) begin
        if (rst)                  low_run <= '0;
        else if (host_rdy)        low_run <= '0;
        else if (low_run != RUN_MAX) low_run <= low_run + 1'b1;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!pdata_stb_n && !paddr_stb_n)); // R1

    AST_NO_SPURIOUS_STB: assert property (@(posedge clk) disable iff (rst)
        host_rd_n && host_wr_n && !stb_on |=> !stb_on); // R1

    AST_RDY_ONLY_ON_WAIT: assert property (@(posedge clk) disable iff (rst)
        !host_rdy |-> stb_on && !pwait_n); // R2

    AST_RDY_BOUND: assert property (@(posedge clk) disable iff (rst)
        !host_rdy |-> low_run < RUN_MAX); // R3

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !pwrite_n |-> pd_oe && !pdir && stb_on); // R4

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stb_on && pwrite_n |-> pdir && !pd_oe); // R5

    AST_STB_ENDS: assert property (@(posedge clk) disable iff (rst)
        stb_on && host_rd_n && host_wr_n |=> !stb_on); // R4 R5

endmodule

bind epp_bridge epp_bridge_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_rdy    (host_rdy),
    .host_rd_n   (host_rd_n),
    .host_wr_n   (host_wr_n),
    .pwait_n     (pwait_n),
    .pdata_stb_n (pdata_stb_n),
    .paddr_stb_n (paddr_stb_n),
    .pwrite_n    (pwrite_n),
    .pdir        (pdir),
    .pd_oe       (pd_oe)
);

// File: tb/epp_bridge_test.sv
module epp_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] host_addr = 3'd5;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd_n = 1'b1;
    logic       host_wr_n = 1'b1;
    logic [7:0] host_rdata;
    logic       host_rdy;
    logic [7:0] pd_in = 8'h00;
    logic [7:0] pd_out;
    logic       pd_oe;
    logic       pdata_stb_n;
    logic       paddr_stb_n;
    logic       pwrite_n;
    logic       pdir;
    logic       pwait_n = 1'b1;
    logic       pint_in = 1'b0;
    logic       pint_out;
    logic       preset_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_latch = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_bridge #(.TMO_CYCLES(TMO)) uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .pdata_stb_n(pdata_stb_n), .paddr_stb_n(paddr_stb_n), .pwrite_n(pwrite_n),
        .pdir(pdir), .pwait_n(pwait_n), .pint_in(pint_in), .pint_out(pint_out),
        .preset_n(preset_n)
    );

    function automatic logic [1:0] exp_strobes(input bit active, input bit adr);
        return active ? (adr ? 2'b10 : 2'b01) : 2'b11; // {pdata_stb_n, paddr_stb_n}
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_n = 1'b0;
        @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic epp_xfer(input bit rd, input bit adr, input logic [7:0] d, input int nwait);
        @(negedge clk);
        host_addr = adr ? 3'd3 : 3'd4;
        pwait_n = (nwait == 0);
        if (rd) begin pd_in = d; host_rd_n = 1'b0; end
        else begin host_wdata = d; host_wr_n = 1'b0; end
        for (int i = 1; i <= nwait; i++) begin
            @(negedge clk);
            check("R1 strobe select", {pdata_stb_n, paddr_stb_n}, exp_strobes(1, adr));
            check("R2 ready low on wait", host_rdy, 0);
            if (i == nwait) pwait_n = 1'b1;
        end
        @(negedge clk);
        if (nwait == 0) @(negedge clk);
        check("R2 ready after wait", host_rdy, 1);
        check("R2 strobe held", {pdata_stb_n, paddr_stb_n}, exp_strobes(1, adr));
        if (rd) begin
            check("R5 read data", host_rdata, d);
            check("R5 read dir/oe/write", {pdir, pd_oe, pwrite_n}, 3'b101);
            host_rd_n = 1'b1;
        end else begin
            check("R4 write drive", pd_out, d);
            check("R4 write dir/oe/write", {pdir, pd_oe, pwrite_n}, 3'b010);
            host_wr_n = 1'b1;
            exp_latch = d;
        end
        @(negedge clk);
        check(rd ? "R5 strobe end" : "R4 strobe end", {pdata_stb_n, paddr_stb_n}, 2'b11);
        if (rd) check("R5 data held", host_rdata, d);
        else begin
            check("R4 latch drives bus", pd_out, exp_latch);
            host_addr = 3'd0;
            #1 check("R4 latch readback", host_rdata, exp_latch);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 strobes", {pdata_stb_n, paddr_stb_n, pwrite_n}, 3'b111);
        check("R9 dir/oe", {pdir, pd_oe}, 2'b01);
        check("R9 reset/ready", {preset_n, host_rdy}, 2'b11);
        host_addr = 3'd2; #1 check("R9 ctrl zero", host_rdata, 0);
        host_addr = 3'd0; #1 check("R9 latch zero", host_rdata, 0);
        host_addr = 3'd1; #1 check("R9 status zero", host_rdata, 0);

        // R1 non-EPP offsets never strobe
        for (int a = 0; a < 3; a++) begin
            @(negedge clk);
            host_addr = 3'(a); host_rd_n = 1'b0;
            @(negedge clk);
            check("R1 no strobe at local offset", {pdata_stb_n, paddr_stb_n}, 2'b11);
            host_rd_n = 1'b1;
        end

        // directed transfers
        epp_xfer(0, 1, 8'hA5, 0);
        epp_xfer(0, 0, 8'h3C, 3);
        epp_xfer(1, 1, 8'h5A, 2);
        epp_xfer(1, 0, 8'hC3, 0);
        epp_xfer(1, 0, 8'h81, TMO);

        // R3 time-out
        @(negedge clk);
        host_addr = 3'd4; pwait_n = 1'b0; pd_in = 8'h12; host_rd_n = 1'b0;
        begin
            int low = 0;
            for (int i = 0; i < 4 * TMO; i++) begin
                @(negedge clk);
                if (!host_rdy) low++;
                else break;
            end
            check("R3 stretch length", low, TMO);
        end
        check("R3 timed-out read byte", host_rdata, 8'hFF);
        host_rd_n = 1'b1;
        @(negedge clk);
        pwait_n = 1'b1;
        host_addr = 3'd1; #1 check("R3 sticky flag set", host_rdata[0], 1);
        epp_xfer(0, 0, 8'h66, 1);
        host_addr = 3'd1; #1 check("R3 flag stays set", host_rdata[0], 1);
        reg_write(3'd1, 8'h00);
        host_addr = 3'd1; #1 check("R3 no clear without bit0", host_rdata[0], 1);
        reg_write(3'd1, 8'h01);
        host_addr = 3'd1; #1 check("R3 flag cleared", host_rdata[0], 0);

        // R6 direction bit
        reg_write(3'd2, 8'h01);
        check("R6 rest with dir set", {pdir, pd_oe, pwrite_n}, 3'b101);
        epp_xfer(1, 1, 8'h9E, 1);
        reg_write(3'd2, 8'h00);
        check("R6 rest with dir clear", {pdir, pd_oe}, 2'b01);

        // R7 peripheral reset
        reg_write(3'd2, 8'h02);
        check("R7 preset low", preset_n, 0);
        host_addr = 3'd2; #1 check("R7 ctrl readback", host_rdata, 8'h02);
        reg_write(3'd2, 8'h00);
        check("R7 preset high", preset_n, 1);

        // R4 direct latch write at offset 0
        reg_write(3'd0, 8'h4B);
        exp_latch = 8'h4B;
        check("R4 latch direct write", pd_out, 8'h4B);

        // R8 interrupt and status bits
        @(negedge clk);
        pint_in = 1'b1; pwait_n = 1'b0; host_addr = 3'd1;
        #1 check("R8 interrupt pass", pint_out, 1);
        check("R8 status irq/wait", host_rdata[2:1], 2'b11);
        check("R2 ready high when idle", host_rdy, 1);
        pint_in = 1'b0; pwait_n = 1'b1;
        #1 check("R8 interrupt low", {pint_out, host_rdata[2:1]}, 3'b000);

        // random transfers
        for (int n = 0; n < 40; n++) begin
            bit rd = 1'($urandom % 2);
            bit adr = 1'($urandom % 2);
            logic [7:0] d = 8'($urandom);
            int w = int'($urandom % 6);
            epp_xfer(rd, adr, d, w);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule